// File: doc/BRIEF.md
# Reset Boot-Source Selector

This block decides, once per reset, whether the processor starts fetching from the flash program store or from the boot ROM. When reset is released it watches two things. The first is a sensed override level on a dedicated pin. The second is a stored option flag from non-volatile configuration. If the override stays present for a set number of instruction cycles after reset release, the block selects the boot ROM and ignores the stored flag. Otherwise the stored flag chooses the memory space.

The decision is registered and announced with a valid strobe, together with the start address for the chosen space. It then stays fixed until the next reset. The override pin has two further uses, independent of the decision. While it is held high, the block raises an enable that routes the internal load clock onto the serial clock pin for the boot loader. It also returns the pin's level to software as a readable bit.

Top module: `boot_src_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `boot_valid`=0, `boot_rom`=0, `start_addr`=0 and `sclk_oe`=0.
- R2: If `force_in` is 1 at every edge after reset release up to and including the edge of the `HOLD_TICKS`-th (default 3) `cyc_tick`, the block reports `boot_valid`=1 and `boot_rom`=1 after that edge, whatever `boot_flag` is.
- R3: Without a recognised override, `boot_flag`=1 selects flash: `boot_valid`=1, `boot_rom`=0, `start_addr`=`FLASH_START` (default 0).
- R4: Without a recognised override, `boot_flag`=0 selects boot ROM: `boot_rom`=1, `start_addr`=`ROM_START` (default 0).
- R5: If `force_in` is sampled low at any edge before the hold completes (including the edge of the final tick), the decision follows `boot_flag` after that edge.
- R6: Only edges with `cyc_tick`=1 advance the hold count. While `force_in` stays high with no tick, `boot_valid` stays 0.
- R7: Once `boot_valid` is 1, `boot_valid`, `boot_rom` and `start_addr` do not change until `rst_n` goes low, whatever `force_in` and `boot_flag` do.
- R8: `sclk_oe` equals the `force_in` value sampled at the previous edge while out of reset, and is 0 whenever that sample is 0.
- R9: `force_rd` reports the `force_in` level sampled at the previous edge, so an applied override reads as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low; its release starts the decision |
| cyc_tick | input | 1 | One-clock pulse per instruction cycle |
| force_in | input | 1 | Sensed override level (1 = override applied) |
| boot_flag | input | 1 | Stored option flag (1 = start from flash) |
| boot_valid | output | 1 | Decision made for this reset |
| boot_rom | output | 1 | Selected space: 1 = boot ROM, 0 = flash |
| start_addr | output | ADDR_W | Start address in the selected space |
| sclk_oe | output | 1 | Drives the load clock onto the serial clock pin |
| force_rd | output | 1 | Override pin level as seen by software |

## Verification
Two things can land on the same edge: the tick that would complete the override hold, and the override falling away. The bench lowers `force_in` exactly on the edge of the third tick. It expects the stored flag to decide the space, so the low sample wins over the tick. A second pair also coincides: the decision strobe and the serial clock enable share the first edges after release. That is judged by checking `sclk_oe` and `force_rd` on the same sample as the decision outputs in each table row.

// File: rtl/bootsel_pkg.sv
package bootsel_pkg;

  typedef enum logic [0:0] {
    SEL_EVAL = 1'b0,
    SEL_DONE = 1'b1
  } sel_state_e;

  typedef struct packed {
    logic valid;
    logic rom;
  } sel_dec_t;

endpackage

// File: rtl/bootsel_hold_cnt.sv
module bootsel_hold_cnt #(
  parameter int HOLD_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic hit
);
  localparam int CNT_W = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  // hit on the edge that carries the final qualifying tick
  assign hit = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bootsel_decide.sv
module bootsel_decide
  import bootsel_pkg::*;
#(
  parameter int              ADDR_W      = 15,
  parameter logic [ADDR_W-1:0] ROM_START   = '0,
  parameter logic [ADDR_W-1:0] FLASH_START = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_in,
  input  logic              boot_flag,
  input  logic              hold_hit,
  output logic              evaluating,
  output sel_dec_t          dec,
  output logic [ADDR_W-1:0] start_addr
);
  sel_state_e state_q;

  assign evaluating = (state_q == SEL_EVAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SEL_EVAL;
      dec        <= '0;
      start_addr <= '0;
    end else if (state_q == SEL_EVAL) begin
      if (!force_in) begin
        // override absent or withdrawn: the stored flag decides
        state_q    <= SEL_DONE;
        dec.valid  <= 1'b1;
        dec.rom    <= ~boot_flag;
        start_addr <= boot_flag ? FLASH_START : ROM_START;
      end else if (hold_hit) begin
        state_q    <= SEL_DONE;
        dec.valid  <= 1'b1;
        dec.rom    <= 1'b1;
        start_addr <= ROM_START;
      end
    end
  end
endmodule

// File: rtl/bootsel_pin_ctl.sv
module bootsel_pin_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic force_in,
  output logic sclk_oe,
  output logic force_rd
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_oe  <= 1'b0;
      force_rd <= 1'b0;
    end else begin
      sclk_oe  <= force_in;
      force_rd <= force_in;
    end
  end
endmodule

// File: rtl/boot_src_sel.sv
module boot_src_sel
  import bootsel_pkg::*;
#(
  parameter int                ADDR_W      = 15,
  parameter int                HOLD_TICKS  = 3,
  parameter logic [ADDR_W-1:0] ROM_START   = '0,
  parameter logic [ADDR_W-1:0] FLASH_START = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_tick,
  input  logic              force_in,
  input  logic              boot_flag,
  output logic              boot_valid,
  output logic              boot_rom,
  output logic [ADDR_W-1:0] start_addr,
  output logic              sclk_oe,
  output logic              force_rd
);
  logic     evaluating;
  logic     hold_hit;
  sel_dec_t dec;

  bootsel_hold_cnt #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (evaluating && force_in),
    .tick  (cyc_tick),
    .hit   (hold_hit)
  );

  bootsel_decide #(
    .ADDR_W      (ADDR_W),
    .ROM_START   (ROM_START),
    .FLASH_START (FLASH_START)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_in   (force_in),
    .boot_flag  (boot_flag),
    .hold_hit   (hold_hit),
    .evaluating (evaluating),
    .dec        (dec),
    .start_addr (start_addr)
  );

  bootsel_pin_ctl u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .force_in (force_in),
    .sclk_oe  (sclk_oe),
    .force_rd (force_rd)
  );

  assign boot_valid = dec.valid;
  assign boot_rom   = dec.rom;
endmodule

// File: rtl/boot_src_sel_chk.sv
module boot_src_sel_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_tick,
  input logic              force_in,
  input logic              boot_flag,
  input logic              boot_valid,
  input logic              boot_rom,
  input logic [ADDR_W-1:0] start_addr,
  input logic              sclk_oe,
  input logic              force_rd
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!boot_valid && !boot_rom && !sclk_oe));

  a_r5_drop_uses_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_valid && !force_in) |=> (boot_valid && (boot_rom == !$past(boot_flag))));

  a_r6_no_tick_no_decision: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_valid && force_in && !cyc_tick) |=> !boot_valid);

  a_r7_decision_held: assert property (@(posedge clk) disable iff (!rst_n)
    boot_valid |=> (boot_valid && $stable(boot_rom) && $stable(start_addr)));

  a_r8_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
    !force_in |=> !sclk_oe);

  a_r8_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    force_in |=> sclk_oe);

  a_r9_pin_reads_high: assert property (@(posedge clk) disable iff (!rst_n)
    force_in |=> force_rd);
endmodule

bind boot_src_sel boot_src_sel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_tick   (cyc_tick),
  .force_in   (force_in),
  .boot_flag  (boot_flag),
  .boot_valid (boot_valid),
  .boot_rom   (boot_rom),
  .start_addr (start_addr),
  .sclk_oe    (sclk_oe),
  .force_rd   (force_rd)
);

// File: tb/boot_src_sel_tb_top.sv
module boot_src_sel_tb_top;
  localparam int ADDR_W = 15;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cyc_tick = 1'b0;
  logic              force_in = 1'b0;
  logic              boot_flag = 1'b1;
  logic              boot_valid, boot_rom, sclk_oe, force_rd;
  logic [ADDR_W-1:0] start_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  boot_src_sel #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .force_in(force_in),
    .boot_flag(boot_flag), .boot_valid(boot_valid), .boot_rom(boot_rom),
    .start_addr(start_addr), .sclk_oe(sclk_oe), .force_rd(force_rd)
  );

  // {flag[7], tick divider[6:5], force length in cycles[3:0]}
  localparam int NV = 12;
  localparam logic [7:0] VEC [NV] = '{
    8'h80 | 8'h20 | 8'd0,  8'h00 | 8'h20 | 8'd0,
    8'h80 | 8'h20 | 8'd3,  8'h00 | 8'h20 | 8'd3,
    8'h80 | 8'h20 | 8'd2,  8'h00 | 8'h20 | 8'd2,
    8'h80 | 8'h20 | 8'd1,  8'h80 | 8'h20 | 8'd6,
    8'h80 | 8'h40 | 8'd4,  8'h80 | 8'h40 | 8'd5,
    8'h80 | 8'h60 | 8'd6,  8'h80 | 8'h60 | 8'd7
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic frc);
    @(negedge clk);
    rst_n = 1'b0; force_in = frc; cyc_tick = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state while the override is applied
    do_reset(1'b1);
    chk("R1", "valid in reset", 32'(boot_valid), 0);
    chk("R1", "rom in reset", 32'(boot_rom), 0);
    chk("R1", "addr in reset", 32'(start_addr), 0);
    chk("R1", "sclk_oe in reset", 32'(sclk_oe), 0);

    // table walk: R2, R3, R4, R5, R6, R8, R9
    for (int v = 0; v < NV; v++) begin
      logic flg;
      int div, len, ticks, exp_rom;
      flg = VEC[v][7];
      div = int'(VEC[v][6:5]);
      len = int'(VEC[v][3:0]);
      ticks = (len + div - 1) / div;
      exp_rom = (ticks >= 3) ? 1 : (flg ? 0 : 1);
      do_reset(len > 0);
      boot_flag = flg;
      rst_n = 1'b1;
      for (int j = 0; j < 10; j++) begin
        force_in = (j < len);
        cyc_tick = ((j % div) == 0);
        @(negedge clk);
        chk("R8", "sclk_oe tracks pin", 32'(sclk_oe), 32'(j < len));
        chk("R9", "pin readback", 32'(force_rd), 32'(j < len));
      end
      chk(exp_rom ? "R2" : "R5", "valid", 32'(boot_valid), 1);
      chk(len == 0 ? (flg ? "R3" : "R4") : (exp_rom ? "R2" : "R5"),
          "rom select", 32'(boot_rom), 32'(exp_rom));
      chk(exp_rom ? "R4" : "R3", "start addr", 32'(start_addr), 0);
    end

    // R6: override held with no ticks does not decide
    do_reset(1'b1);
    boot_flag = 1'b1; rst_n = 1'b1; cyc_tick = 1'b0;
    repeat (12) @(negedge clk);
    chk("R6", "no tick keeps pending", 32'(boot_valid), 0);
    cyc_tick = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6", "three ticks decide", 32'(boot_valid), 1);
    chk("R6", "rom after ticks", 32'(boot_rom), 1);

    // R5 corner: override falls on the edge of the final tick
    do_reset(1'b1);
    boot_flag = 1'b1; rst_n = 1'b1; cyc_tick = 1'b1;
    repeat (2) @(negedge clk);
    force_in = 1'b0;
    @(negedge clk);
    chk("R5", "drop on last tick valid", 32'(boot_valid), 1);
    chk("R5", "drop on last tick flash", 32'(boot_rom), 0);

    // R7: decision held while pin and flag move
    force_in = 1'b1; boot_flag = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7", "held valid", 32'(boot_valid), 1);
    chk("R7", "held flash", 32'(boot_rom), 0);
    chk("R8", "oe after decision", 32'(sclk_oe), 1);
    force_in = 1'b0;
    @(negedge clk);
    chk("R8", "oe drops", 32'(sclk_oe), 0);
    chk("R7", "still flash", 32'(boot_rom), 0);

    // R1: new reset clears the latched decision
    do_reset(1'b0);
    chk("R1", "valid cleared", 32'(boot_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4", "flag clear picks rom", 32'(boot_rom), 1);

    finish_run();
  end
endmodule